// File: doc/BRIEF.md
# Watchdog Timer with Keyed Service and Reset-Cause Flag

This block is a watchdog timer for a small microcontroller. A free-running counter advances on every system clock. Software must keep restarting it by writing a two-byte key to a service register. If the counter reaches the end of its period while the watchdog is enabled, the block raises a reset request for a fixed number of cycles. A second source of reset requests is an external slow-clock indication from an analog clock monitor. A sticky flag in the status register lets the reset service routine tell a watchdog expiry apart from a slow-clock event.

The block sits on a simple write/read register port with two locations. The service register is at address 0x1D. The status register is at address 0x1E. A development-mode input changes two things. It allows software to switch off the reset action of the watchdog, which is useful while a debugger holds the processor. It also latches the slow-clock monitor off until the next power-on reset. Turning the reset action off never stops the counter. Only the key sequence or a reset restarts it.

Top module: `wdog_unlock`

## Requirements
- R1: A read of address 0x1E returns bit 1 = enable, bit 0 = expiry flag, and bits 7..2 = 0. A read of 0x1D, or of any other address, returns 0.
- R2: The counter advances by one on every clock. The TIMEOUT-th rising edge after the counter was last cleared raises the reset request. With TIMEOUT = 64, a clear at edge E gives a request sampled high after edge E+64 and low after edge E+63.
- R3: Writing 0x55 to 0x1D and then 0xAA to 0x1D, as consecutive writes to that address, clears the counter on the edge that captures the 0xAA.
- R4: A write of any other value to 0x1D between the 0x55 and the 0xAA breaks the sequence, and the 0xAA then has no effect. Writes to other addresses do not break it.
- R5: While the enable bit is 0, an expiry raises no request and does not set the flag. The counter keeps running and wraps to 0 at the end of each period.
- R6: Power-on reset, the general reset input and the block's own reset request all set the enable bit. A write to 0x1E loads its bit 1 into the enable bit only while the development-mode input is high. Otherwise the write is ignored.
- R7: The expiry flag is set when a watchdog expiry raises the request. A write of 0x00 to 0x1D clears it. A slow-clock request does not set it.
- R8: The expiry flag keeps its value through the general reset and through the block's own reset request. Only power-on reset clears it.
- R9: While the development-mode input is low and detection has not been disabled, a high on the slow-clock input raises the reset request on the next edge.
- R10: Once the development-mode input has been seen high, slow-clock events are ignored until the next power-on reset.
- R11: The reset request lasts exactly REQ_CYC cycles (3 in the bench). The counter is held at 0 while the request is high and is cleared by the general reset input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| sys_rst | input | 1 | General (non-power-on) reset, active high, synchronous |
| dev_mode | input | 1 | Development-mode control |
| slow_det | input | 1 | Slow-clock indication from the clock monitor |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cop_rst_req | output | 1 | Reset request to the system |

## Verification
The hardest case to reach is the proof that a disabled watchdog keeps counting. From the ports, that shows only as the time at which a later expiry happens. The bench disables the reset action in development mode and services the counter. It then lets one full period pass silently, and re-enables the watchdog without servicing it. The request must then arrive exactly two periods after the service, not one period after the re-enable. A broken key sequence is handled the same way: the bench checks the time of the resulting expiry to tell whether a late 0xAA took effect.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;
  localparam logic [DATA_W-1:0] FLAG_CLEAR = 8'h00;
  localparam int EN_BIT   = 1;
  localparam int FLAG_BIT = 0;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;
endpackage

// File: rtl/wdog_tick_ctr.sv
module wdog_tick_ctr #(
  parameter int TIMEOUT = 65536
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   clr,
  output logic [((TIMEOUT > 1) ? $clog2(TIMEOUT) : 1)-1:0] cnt,
  output logic                                   expire
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_d;

  assign expire = (cnt == LAST);

  always_comb begin
    if (clr || expire) cnt_d = '0;
    else               cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              svc_clr
);
  key_state_e st_q, st_d;

  assign svc_clr = key_wr && (st_q == KEY_ARMED) && (key_data == KEY_SECOND);

  always_comb begin
    st_d = st_q;
    if (abort)       st_d = KEY_IDLE;
    else if (key_wr) st_d = (key_data == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wdog_req_gen.sv
module wdog_req_gen #(
  parameter int REQ_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic req
);
  localparam int RW = $clog2(REQ_CYC + 1);

  logic [RW-1:0] left_q, left_d;
  logic          left_en;

  assign req     = (left_q != '0);
  assign left_en = start || req;

  always_comb begin
    if (start) left_d = RW'(REQ_CYC);
    else       left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end
endmodule

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
#(
  parameter int              TIMEOUT   = 65536,
  parameter int              REQ_CYC   = 4,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] RST_ADDR  = 8'h1D,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h1E
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst,
  input  logic              dev_mode,
  input  logic              slow_det,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              cop_rst_req
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  logic [1:0]    sync_q;
  logic          rst_s;
  logic [CW-1:0] tick_cnt;
  logic          tick_expire;
  logic          svc_clr;
  logic          wr_rst, wr_stat, any_rst;
  logic          wd_hit, slow_hit, req_start;
  logic          wde_q, wde_d, wde_en;
  logic          wdf_q, wdf_d, wdf_en;
  logic          slow_dis_q;

  // power-on reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s = sync_q[1];

  assign wr_rst    = bus_wr && (bus_addr == RST_ADDR);
  assign wr_stat   = bus_wr && (bus_addr == STAT_ADDR);
  assign any_rst   = sys_rst || cop_rst_req;
  assign wd_hit    = tick_expire && wde_q && !sys_rst;
  assign slow_hit  = slow_det && !dev_mode && !slow_dis_q;
  assign req_start = (wd_hit || slow_hit) && !cop_rst_req;

  wdog_tick_ctr #(.TIMEOUT(TIMEOUT)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_s),
    .clr    (any_rst || svc_clr),
    .cnt    (tick_cnt),
    .expire (tick_expire)
  );

  wdog_key_seq u_key (
    .clk      (clk),
    .rst_n    (rst_s),
    .abort    (any_rst),
    .key_wr   (wr_rst),
    .key_data (bus_wdata),
    .svc_clr  (svc_clr)
  );

  wdog_req_gen #(.REQ_CYC(REQ_CYC)) u_req (
    .clk   (clk),
    .rst_n (rst_s),
    .start (req_start),
    .req   (cop_rst_req)
  );

  // enable bit: forced on by any reset, writable only in development mode
  always_comb begin
    wde_en = any_rst || (wr_stat && dev_mode);
    wde_d  = any_rst ? 1'b1 : bus_wdata[EN_BIT];
  end

  // expiry flag: set by watchdog expiry, cleared by key register write of zero
  always_comb begin
    wdf_en = (wd_hit && req_start) || (wr_rst && (bus_wdata == FLAG_CLEAR));
    wdf_d  = wd_hit && req_start;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wde_q      <= 1'b1;
      wdf_q      <= 1'b0;
      slow_dis_q <= 1'b0;
    end else begin
      if (wde_en)   wde_q      <= wde_d;
      if (wdf_en)   wdf_q      <= wdf_d;
      if (dev_mode) slow_dis_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STAT_ADDR) begin
      bus_rdata[EN_BIT]   = wde_q;
      bus_rdata[FLAG_BIT] = wdf_q;
    end
  end
endmodule

// File: rtl/wdog_unlock_chk.sv
module wdog_unlock_chk
  import wdog_pkg::*;
#(
  parameter int              TIMEOUT  = 65536,
  parameter int              REQ_CYC  = 4,
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] RST_ADDR = 8'h1D,
  parameter int              CW       = 16
) (
  input logic              clk,
  input logic              rst_s,
  input logic              req,
  input logic              wde,
  input logic              wdf,
  input logic              slow_dis,
  input logic [CW-1:0]     cnt,
  input logic              expire,
  input logic              svc_clr,
  input logic              sys_rst,
  input logic              dev_mode,
  input logic              slow_det,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata
);
  localparam int LW = $clog2(REQ_CYC + 2);
  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)   len_q <= '0;
    else if (req) len_q <= len_q + 1'b1;
    else          len_q <= '0;
  end

  // R11
  req_len_max_chk: assert property (@(posedge clk) disable iff (!rst_s)
    req |-> (len_q < LW'(REQ_CYC)));
  // R11
  req_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(req) |-> (len_q == LW'(REQ_CYC)));
  // R2
  cnt_run_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!req && !sys_rst && !svc_clr && !expire) |=> (cnt == CW'($past(cnt) + 1'b1)));
  // R7
  wdf_set_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(wdf) |-> $rose(req));
  // R8
  wdf_clr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(wdf) |-> $past(bus_wr && (bus_addr == RST_ADDR) && (bus_wdata == 8'h00)));
  // R6
  wde_clr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(wde) |-> $past(dev_mode));
  // R5
  wde_gate_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (expire && !wde && !req && !slow_det) |=> !req);
  // R10
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(req) |-> $past((expire && wde) || (slow_det && !dev_mode && !slow_dis)));
endmodule

bind wdog_unlock wdog_unlock_chk #(
  .TIMEOUT (TIMEOUT),
  .REQ_CYC (REQ_CYC),
  .ADDR_W  (ADDR_W),
  .RST_ADDR(RST_ADDR),
  .CW      (CW)
) u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .req      (cop_rst_req),
  .wde      (wde_q),
  .wdf      (wdf_q),
  .slow_dis (slow_dis_q),
  .cnt      (tick_cnt),
  .expire   (tick_expire),
  .svc_clr  (svc_clr),
  .sys_rst  (sys_rst),
  .dev_mode (dev_mode),
  .slow_det (slow_det),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata)
);

// File: tb/wdog_unlock_bench.sv
module wdog_unlock_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;
  localparam int RQC = 3;

  logic       clk;
  logic       por_n, sys_rst, dev_mode, slow_det, bus_wr;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       cop_rst_req;

  int checks = 0;
  int fails  = 0;
  int pos    = 0;
  bit done   = 0;

  wdog_unlock #(.TIMEOUT(TMO), .REQ_CYC(RQC)) u_wdog_unlock (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .dev_mode(dev_mode),
    .slow_det(slow_det), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cop_rst_req(cop_rst_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pos++;
    end
  endtask

  task automatic wait_to(input int target);
    while (pos < target) step(1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    step(2);
    por_n = 1'b1;
    step(3);
  endtask

  task automatic service();
    wr(8'h1D, 8'h55);
    wr(8'h1D, 8'hAA);
    pos = 0;
  endtask

  task automatic t_reset_state();
    do_por();
    chk("R11 req idle after por", {7'b0, cop_rst_req}, 8'h00);
    rd_chk("R1 status after por", 8'h1E, 8'h02);
    rd_chk("R1 key reg reads zero", 8'h1D, 8'h00);
    rd_chk("R1 other addr reads zero", 8'h10, 8'h00);
  endtask

  task automatic t_timeout();
    do_por();
    service();
    wait_to(TMO - 1);
    chk("R2 no req one edge early", {7'b0, cop_rst_req}, 8'h00);
    wait_to(TMO);
    chk("R2 req at timeout", {7'b0, cop_rst_req}, 8'h01);
    wait_to(TMO + RQC - 1);
    chk("R11 req still high at last cycle", {7'b0, cop_rst_req}, 8'h01);
    wait_to(TMO + RQC);
    chk("R11 req ends after REQ_CYC", {7'b0, cop_rst_req}, 8'h00);
    rd_chk("R7 flag set by expiry", 8'h1E, 8'h03);
    sys_rst = 1'b1; step(1); sys_rst = 1'b0;
    rd_chk("R8 flag survives general reset", 8'h1E, 8'h03);
    wr(8'h1D, 8'h00);
    rd_chk("R7 zero write clears flag", 8'h1E, 8'h02);
    service();
    wait_to(TMO + 2);
    do_por();
    rd_chk("R8 por clears flag", 8'h1E, 8'h02);
  endtask

  task automatic t_broken_key();
    do_por();
    service();
    wait_to(40);
    wr(8'h1D, 8'h55);
    wr(8'h1D, 8'h12);
    wr(8'h1D, 8'hAA);
    wait_to(TMO - 1);
    chk("R4 broken key no early req", {7'b0, cop_rst_req}, 8'h00);
    wait_to(TMO);
    chk("R4 broken key did not clear", {7'b0, cop_rst_req}, 8'h01);
    do_por();
    service();
    wait_to(40);
    wr(8'h1D, 8'h55);
    wr(8'h1E, 8'h00);
    wr(8'h1D, 8'hAA);
    wait_to(TMO);
    chk("R3 key across other addr cleared", {7'b0, cop_rst_req}, 8'h00);
    wait_to(43 + TMO - 1);
    chk("R3 no req before new period", {7'b0, cop_rst_req}, 8'h00);
    wait_to(43 + TMO);
    chk("R3 req one period after key", {7'b0, cop_rst_req}, 8'h01);
  endtask

  task automatic t_disabled_runs();
    do_por();
    dev_mode = 1'b1;
    wr(8'h1E, 8'h00);
    rd_chk("R6 dev mode clears enable", 8'h1E, 8'h00);
    service();
    wait_to(TMO);
    chk("R5 no req while disabled", {7'b0, cop_rst_req}, 8'h00);
    rd_chk("R5 flag not set while disabled", 8'h1E, 8'h00);
    wr(8'h1E, 8'h02);
    dev_mode = 1'b0;
    wait_to(2 * TMO - 1);
    chk("R5 counter kept running early", {7'b0, cop_rst_req}, 8'h00);
    wait_to(2 * TMO);
    chk("R5 req two periods after service", {7'b0, cop_rst_req}, 8'h01);
  endtask

  task automatic t_enable_rules();
    do_por();
    wr(8'h1E, 8'h00);
    rd_chk("R6 write ignored outside dev mode", 8'h1E, 8'h02);
    dev_mode = 1'b1;
    wr(8'h1E, 8'h00);
    dev_mode = 1'b0;
    sys_rst = 1'b1; step(1); sys_rst = 1'b0;
    rd_chk("R6 general reset sets enable", 8'h1E, 8'h02);
    do_por();
    service();
    wait_to(30);
    sys_rst = 1'b1; step(1); sys_rst = 1'b0;
    wait_to(31 + TMO - 1);
    chk("R11 general reset cleared counter", {7'b0, cop_rst_req}, 8'h00);
    wait_to(31 + TMO);
    chk("R11 req one period after reset", {7'b0, cop_rst_req}, 8'h01);
  endtask

  task automatic t_slow_clock();
    do_por();
    slow_det = 1'b1; step(1); slow_det = 1'b0;
    chk("R9 slow clock raises req", {7'b0, cop_rst_req}, 8'h01);
    rd_chk("R7 slow clock leaves flag clear", 8'h1E, 8'h02);
    step(RQC);
    chk("R11 slow req ended", {7'b0, cop_rst_req}, 8'h00);
    dev_mode = 1'b1; step(1); dev_mode = 1'b0; step(1);
    slow_det = 1'b1; step(1); slow_det = 1'b0;
    chk("R10 slow clock ignored after dev mode", {7'b0, cop_rst_req}, 8'h00);
    step(2);
    chk("R10 still no req", {7'b0, cop_rst_req}, 8'h00);
    do_por();
    slow_det = 1'b1; step(1); slow_det = 1'b0;
    chk("R10 por re-enables detection", {7'b0, cop_rst_req}, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; sys_rst = 1'b0; dev_mode = 1'b0; slow_det = 1'b0;
    bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
    t_reset_state();
    t_timeout();
    t_broken_key();
    t_disabled_runs();
    t_enable_rules();
    t_slow_clock();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule